// File: doc/BRIEF.md
# Enabled Eight-Bit Zero Counter with No-Zero Flag

This block is purely combinational. It looks at an eight-bit input word and reports, as a four-bit unsigned binary number, how many of those bits are 0. Where the zeros sit in the word does not matter. An enable input gates both results. While the block is disabled, the count reads zero and the flag stays low. A separate flag output goes high when the block is enabled and the word contains no zero bits at all.

Inside, the word is split into two four-bit groups. A small counter cell handles each group. It produces a three-bit partial count and a group-level "no zeros here" flag. A ripple adder sums the two partial counts, and the adder's carry-out becomes the top bit of the result. The block widens in the same way: two eight-bit blocks and one more adder level give a sixteen-input counter.

Top module: `zero_count8`

## Requirements
- R1: With `en` = 1, `zcount` equals the number of bits of `din` that are 0, read as an unsigned binary value with bit 3 as the most significant bit.
- R2: The count does not depend on bit positions: with `en` = 1, both `din` = 8'b01101101 and `din` = 8'b11100011 give `zcount` = 4'b0011.
- R3: `none_zero` is 1 exactly when `en` = 1 and `din` = 8'hFF; otherwise it is 0.
- R4: With `en` = 0, `zcount` is 4'b0000 and `none_zero` is 0 for every value of `din`.
- R5: With `en` = 1 and `din` = 8'h00, `zcount` is 4'b1000. The carry out of the partial-count adder drives bit 3.
- R6: With `en` = 1, zeros confined to one four-bit half of `din` (the other half all ones) are counted exactly. For example, `din` = 8'hF0 gives 4 and `din` = 8'h0F gives 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 8 | Word whose zero bits are counted |
| en | input | 1 | Enable; when low, both outputs are held inactive |
| zcount | output | 4 | Number of zero bits in `din`, gated by `en` |
| none_zero | output | 1 | High when enabled and `din` has no zero bits |

## Verification
Both results are combinational, so each one is due in the same cycle that a new `din`/`en` pair is applied. No register lies on the path. The bench changes inputs on the falling clock edge and compares both outputs against its own bit-counting model on the following rising edge. That leaves half a period for settling, and the sample point stays clear of the edge where stimulus changes. All 256 words are swept with each enable value, and named corner words are checked on top of the sweep.

// File: rtl/zc_pkg.sv
package zc_pkg;
  localparam int unsigned GROUP_W   = 4;
  localparam int unsigned NUM_GROUP = 2;
  localparam int unsigned WORD_W    = GROUP_W * NUM_GROUP;
  localparam int unsigned PART_W    = $clog2(GROUP_W + 1);
  localparam int unsigned TOTAL_W   = $clog2(WORD_W + 1);
endpackage

// File: rtl/zc_group_cell.sv
module zc_group_cell #(
  parameter int unsigned W  = 4,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o,
  output logic          clear_o
);
  logic [CW-1:0] raw_cnt;

  always_comb begin
    raw_cnt = '0;
    for (int i = 0; i < W; i++) begin
      raw_cnt = raw_cnt + CW'(!bits_i[i]);
    end
  end

  assign cnt_o   = en_i ? raw_cnt : '0;
  assign clear_o = en_i & (&bits_i);

  // A group flagged clear must not report any zeros (R3)
  always_comb begin
    assert_cell_clear_R3: assert (!clear_o || cnt_o == '0)
      else $error("group flag set with nonzero count");
  end
endmodule

// File: rtl/zc_ripple_add.sv
module zc_ripple_add #(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic [W:0] c;
  assign c[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_fa
    assign s_o[k]  = a_i[k] ^ b_i[k] ^ c[k];
    assign c[k+1]  = (a_i[k] & b_i[k]) | (c[k] & (a_i[k] ^ b_i[k]));
  end

  assign co_o = c[W];

  // The carry chain must agree with arithmetic addition (R5)
  always_comb begin
    assert_adder_sum_R5: assert ({co_o, s_o} == ({1'b0, a_i} + {1'b0, b_i}))
      else $error("ripple sum mismatch");
  end
endmodule

// File: rtl/zero_count8.sv
module zero_count8
  import zc_pkg::*;
(
  input  logic [WORD_W-1:0]  din,
  input  logic               en,
  output logic [TOTAL_W-1:0] zcount,
  output logic               none_zero
);
  logic [PART_W-1:0] part  [NUM_GROUP];
  logic              clear [NUM_GROUP];

  for (genvar g = 0; g < NUM_GROUP; g++) begin : g_cell
    zc_group_cell #(.W(GROUP_W)) u_cell (
      .bits_i  (din[g*GROUP_W +: GROUP_W]),
      .en_i    (en),
      .cnt_o   (part[g]),
      .clear_o (clear[g])
    );
  end

  logic [PART_W-1:0] sum_lo;
  logic              sum_co;

  zc_ripple_add #(.W(PART_W)) u_add (
    .a_i  (part[0]),
    .b_i  (part[1]),
    .s_o  (sum_lo),
    .co_o (sum_co)
  );

  assign zcount    = {sum_co, sum_lo};
  assign none_zero = clear[0] & clear[1];

  always_comb begin
    assert_disabled_quiet_R4: assert (en || (zcount == '0 && !none_zero))
      else $error("outputs active while disabled");
    assert_flag_vs_count_R3: assert (none_zero == (en && zcount == '0))
      else $error("flag disagrees with count");
    assert_count_range_R1: assert (zcount <= TOTAL_W'(WORD_W))
      else $error("count exceeds word width");
  end
endmodule

// File: tb/zero_count8_test.sv
module zero_count8_test;
  logic       clk = 1'b0;
  logic [7:0] din;
  logic       en;
  logic [3:0] zcount;
  logic       none_zero;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  zero_count8 uut (.din(din), .en(en), .zcount(zcount), .none_zero(none_zero));

  function automatic int ref_zeros(input logic [7:0] w);
    int n = 0;
    for (int i = 0; i < 8; i++) if (w[i] == 1'b0) n++;
    return n;
  endfunction

  task automatic apply(input logic [7:0] w, input logic e);
    @(negedge clk);
    din = w;
    en  = e;
    @(posedge clk);
  endtask

  task automatic check(input string req, input int exp_cnt, input bit exp_flag);
    n_chk++;
    if (int'(zcount) != exp_cnt || none_zero != exp_flag) begin
      n_bad++;
      $display("FAIL %s din=%b en=%b zcount=%0d none_zero=%b expected zcount=%0d none_zero=%b",
               req, din, en, zcount, none_zero, exp_cnt, exp_flag);
    end
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    din = 8'hFF;
    en  = 1'b0;
    apply(8'hFF, 1'b0);
    check("R4 idle", 0, 1'b0);

    apply(8'b01101101, 1'b1);  check("R2", 3, 1'b0);
    apply(8'b11100011, 1'b1);  check("R2", 3, 1'b0);
    apply(8'h00, 1'b1);        check("R5", 8, 1'b0);
    apply(8'hFF, 1'b1);        check("R3", 0, 1'b1);
    apply(8'hF0, 1'b1);        check("R6", 4, 1'b0);
    apply(8'h0F, 1'b1);        check("R6", 4, 1'b0);
    apply(8'hFE, 1'b1);        check("R6", 1, 1'b0);
    apply(8'h7F, 1'b1);        check("R6", 1, 1'b0);
    apply(8'h00, 1'b0);        check("R4", 0, 1'b0);
    apply(8'hFF, 1'b0);        check("R4 R3", 0, 1'b0);

    for (int e = 0; e < 2; e++) begin
      for (int v = 0; v < 256; v++) begin
        apply(8'(v), e[0]);
        if (e == 0) check("R4 sweep", 0, 1'b0);
        else        check("R1 R3 sweep", ref_zeros(8'(v)), v == 255);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule